// File: doc/BRIEF.md
# Flash Bad Block Scanner

The scanner walks an inclusive range of erase blocks on a raw NAND flash device and records whether each block carries a factory bad-block marker. For every block in the range it asks a separate page-read engine for the first six spare-area bytes of the block's first page. It then applies the marker rule that fits the device geometry and stores a two-bit flag for that block in an internal table. The flash bus timing itself belongs to the page-read engine. The scanner only issues page addresses and consumes the returned spare bytes.

A request gives the first and last block index, the number of blocks on the device, the number of pages per erase block, the bus width and the page size class. The last index may be left unspecified or may point past the device. A start index outside the device is refused. The table can be read at any time through a combinational read port. A one-cycle pulse marks the end of a scan or the refusal of a request.

Top module: `flash_bbscan`

## Requirements
- R1: After reset every table entry reads 2'b00 (unknown), and busy, done and rejected are low.
- R2: For each block b in the scan range, the scanner raises rd_req with rd_page = b * pages_per_blk and holds both steady until rd_done. Spare byte k arrives on rd_spare[8k+7:8k]. Exactly one read is made per block.
- R3: When bus16 is 1, a block is bad when (byte0 & byte1) != 8'hFF.
- R4: When large_page is 0 (512-byte pages), a block is bad when byte5 != 8'hFF.
- R5: When large_page is 1 (2048-byte pages), a block is bad when byte0 != 8'hFF. Byte5 is then ignored.
- R6: A block that fails none of the checks in R3 to R5 is stored as 2'b01 (good). A bad block is stored as 2'b10. The flag is written on the clock edge that samples rd_done.
- R7: A negative last_blk (including all-ones) or a last_blk >= num_blocks is replaced by num_blocks - 1.
- R8: A start whose first_blk is negative or >= num_blocks gives a one-cycle rejected pulse in the following cycle. It makes no read and leaves the table unchanged.
- R9: The range runs from first to last inclusive. If the effective last index is below first, no read is made and done pulses in the following cycle. Entries outside the range are never changed.
- R10: busy is high from the cycle after an accepted start until the edge that stores the final flag. done pulses for exactly one cycle after that edge. A start while busy is ignored, and the configuration is captured when the scan starts.
- R11: Successive read requests within a scan step the page address by pages_per_blk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a scan request |
| first_blk | input | BLK_W+1 | Signed first block index |
| last_blk | input | BLK_W+1 | Signed last block index; negative means unspecified |
| num_blocks | input | BLK_W+1 | Blocks on the device |
| pages_per_blk | input | PAGE_W | Pages in one erase block |
| bus16 | input | 1 | Device has a 16-bit data bus |
| large_page | input | 1 | 1: 2048-byte pages, 0: 512-byte pages |
| rd_req | output | 1 | Page-read request to the read engine |
| rd_page | output | PAGE_W | Page address of the request |
| rd_done | input | 1 | Read engine returns spare bytes |
| rd_spare | input | 48 | Six spare bytes, byte k at bits 8k+7:8k |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| rejected | output | 1 | One-cycle pulse for a refused start |
| tbl_addr | input | BLK_W | Table read address |
| tbl_flag | output | 2 | Flag of the addressed block: 00 unknown, 01 good, 10 bad |

## Verification
The hardest case to reach from the ports is a second start request that lands while a scan is still waiting on the read engine. Such a request must leave the range, the captured geometry and the read sequence of the running scan undisturbed. The stimulus uses a read-engine model with a variable return latency, so the scan stays busy long enough. It then pulses start with a different first index partway through. The scoreboard queue reports any extra or misplaced page request, and a full table comparison afterwards shows whether any entry was disturbed. Clamping and inverted ranges are driven with small block counts, so the final block and the empty range are reached in only a few reads.

// File: rtl/flash_bbscan.sv
module flash_bbscan #(
  parameter int BLK_W  = 6,
  parameter int PAGE_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BLK_W:0]    first_blk,
  input  logic [BLK_W:0]    last_blk,
  input  logic [BLK_W:0]    num_blocks,
  input  logic [PAGE_W-1:0] pages_per_blk,
  input  logic              bus16,
  input  logic              large_page,
  output logic              rd_req,
  output logic [PAGE_W-1:0] rd_page,
  input  logic              rd_done,
  input  logic [47:0]       rd_spare,
  output logic              busy,
  output logic              done,
  output logic              rejected,
  input  logic [BLK_W-1:0]  tbl_addr,
  output logic [1:0]        tbl_flag
);
  localparam int DEPTH = 1 << BLK_W;
  localparam logic [1:0] FLAG_UNK  = 2'b00;
  localparam logic [1:0] FLAG_GOOD = 2'b01;
  localparam logic [1:0] FLAG_BAD  = 2'b10;

  logic [1:0]        tbl [DEPTH];
  logic              busy_q, done_q, rej_q;
  logic [BLK_W-1:0]  cur, last_q;
  logic [PAGE_W-1:0] page_q, ppb_q;
  logic              bus16_q, large_q;

  wire [BLK_W-1:0] first_mag = first_blk[BLK_W-1:0];
  wire [BLK_W-1:0] last_mag  = last_blk[BLK_W-1:0];
  wire first_bad = first_blk[BLK_W] || ({1'b0, first_mag} >= num_blocks);
  wire last_clip = last_blk[BLK_W]  || ({1'b0, last_mag}  >= num_blocks);
  wire [BLK_W:0]   num_m1   = num_blocks - 1'b1;
  wire [BLK_W-1:0] last_eff = last_clip ? num_m1[BLK_W-1:0] : last_mag;
  wire empty = last_eff < first_mag;
  wire [PAGE_W-1:0] page0 = {{(PAGE_W-BLK_W){1'b0}}, first_mag} * pages_per_blk;

  wire [7:0] b0 = rd_spare[7:0];
  wire [7:0] b1 = rd_spare[15:8];
  wire [7:0] b5 = rd_spare[47:40];
  wire blk_bad = (bus16_q && ((b0 & b1) != 8'hFF)) ||
                 (!large_q && (b5 != 8'hFF)) ||
                 (large_q && (b0 != 8'hFF));

  assign rd_req   = busy_q;
  assign rd_page  = page_q;
  assign busy     = busy_q;
  assign done     = done_q;
  assign rejected = rej_q;
  assign tbl_flag = tbl[tbl_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      rej_q   <= 1'b0;
      cur     <= '0;
      last_q  <= '0;
      page_q  <= '0;
      ppb_q   <= '0;
      bus16_q <= 1'b0;
      large_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) tbl[i] <= FLAG_UNK;
    end else begin
      done_q <= 1'b0;
      rej_q  <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          if (first_bad) rej_q <= 1'b1;
          else if (empty) done_q <= 1'b1;
          else begin
            busy_q  <= 1'b1;
            cur     <= first_mag;
            last_q  <= last_eff;
            page_q  <= page0;
            ppb_q   <= pages_per_blk;
            bus16_q <= bus16;
            large_q <= large_page;
          end
        end
      end else if (rd_done) begin
        tbl[cur] <= blk_bad ? FLAG_BAD : FLAG_GOOD;
        if (cur == last_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cur    <= cur + 1'b1;
          page_q <= page_q + ppb_q;
        end
      end
    end
  end
endmodule

// File: rtl/flash_bbscan_chk.sv
module flash_bbscan_chk #(
  parameter int BLK_W  = 6,
  parameter int PAGE_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [BLK_W:0]    first_blk,
  input logic [PAGE_W-1:0] pages_per_blk,
  input logic              rd_req,
  input logic [PAGE_W-1:0] rd_page,
  input logic              rd_done,
  input logic              busy,
  input logic              done,
  input logic              rejected
);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_done) |=> busy);
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_done) |=> (rd_req && $stable(rd_page)));
  assert_page_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_done && $stable(pages_per_blk)) |=>
      (!rd_req || (rd_page == $past(rd_page) + $past(pages_per_blk))));
  assert_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && first_blk[BLK_W]) |=> (rejected && !busy && !done));
endmodule

bind flash_bbscan flash_bbscan_chk #(.BLK_W(BLK_W), .PAGE_W(PAGE_W)) u_chk (.*);

// File: tb/test_flash_bbscan.sv
module test_flash_bbscan;
  localparam int BLK_W = 6;
  localparam int PAGE_W = 24;
  localparam int DEPTH = 1 << BLK_W;

  typedef struct packed {
    logic [PAGE_W-1:0] page;
    logic [47:0]       spare;
  } item_t;

  logic clk = 0, rst_n = 0, start = 0;
  logic [BLK_W:0] first_blk = '0, last_blk = '0, num_blocks = '0;
  logic [PAGE_W-1:0] pages_per_blk = '0;
  logic bus16 = 0, large_page = 0;
  logic rd_req, rd_done = 0;
  logic [PAGE_W-1:0] rd_page;
  logic [47:0] rd_spare = '0;
  logic busy, done, rejected;
  logic [BLK_W-1:0] tbl_addr = '0;
  logic [1:0] tbl_flag;

  int n_chk = 0, n_fail = 0;
  item_t q[$];
  logic [47:0] spr [DEPTH];
  logic [1:0] exp_tbl [DEPTH];
  int lat_sel = 0;

  always #5 clk = ~clk;

  flash_bbscan #(.BLK_W(BLK_W), .PAGE_W(PAGE_W)) i_flash_bbscan (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_flag(input logic [47:0] s, input bit b16, input bit lg);
    logic bad;
    bad = (b16 && ((s[7:0] & s[15:8]) != 8'hFF)) ||
          (!lg && s[47:40] != 8'hFF) || (lg && s[7:0] != 8'hFF);
    return bad ? 2'b10 : 2'b01;
  endfunction

  task automatic check_table(input string tag);
    for (int a = 0; a < DEPTH; a++) begin
      tbl_addr = a[BLK_W-1:0];
      #1;
      chk(tbl_flag == exp_tbl[a], tag, tbl_flag, exp_tbl[a]);
    end
  endtask

  // monitor / read-engine model: pops expected requests and returns spare bytes
  initial begin
    forever begin
      @(negedge clk);
      if (rd_req) begin
        item_t it;
        if (q.size() == 0) begin
          chk(0, "R2 unexpected read request", rd_page, 0);
          it.page = rd_page;
          it.spare = '1;
        end else begin
          it = q.pop_front();
          chk(rd_page == it.page, "R2/R11 page address", rd_page, it.page);
        end
        lat_sel++;
        repeat (1 + lat_sel % 3) @(negedge clk);
        rd_spare = it.spare;
        rd_done = 1;
        @(negedge clk);
        rd_done = 0;
      end
    end
  end

  task automatic run_scan(input int f, input int l, input int n, input int ppb,
                          input bit b16, input bit lg, input bit poke, input string tag);
    int lim, cnt;
    @(negedge clk);
    first_blk = (BLK_W+1)'(f);
    last_blk = (BLK_W+1)'(l);
    num_blocks = (BLK_W+1)'(n);
    pages_per_blk = PAGE_W'(ppb);
    bus16 = b16;
    large_page = lg;
    lim = (l < 0 || l >= n) ? n - 1 : l;
    for (int b = f; b <= lim; b++) begin
      item_t it;
      it.page = PAGE_W'(b * ppb);
      it.spare = spr[b];
      q.push_back(it);
      exp_tbl[b] = exp_flag(spr[b], b16, lg);
    end
    start = 1;
    @(negedge clk);
    start = 0;
    if (lim >= f) chk(busy == 1, {"R10 busy after start ", tag}, busy, 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      first_blk = '0;
      last_blk = '1;
      bus16 = ~b16;
      large_page = ~lg;
      start = 1;
      @(negedge clk);
      start = 0;
    end
    cnt = 0;
    while (!done && cnt < 5000) begin
      @(negedge clk);
      cnt++;
    end
    chk(done == 1, {"R10 done pulse ", tag}, done, 1);
    @(negedge clk);
    chk(done == 0 && busy == 0, {"R10 done one cycle ", tag}, {done, busy}, 0);
    chk(q.size() == 0, {"R2 all reads made ", tag}, q.size(), 0);
    check_table(tag);
  endtask

  task automatic run_reject(input int f, input int n, input string tag);
    @(negedge clk);
    first_blk = (BLK_W+1)'(f);
    last_blk = '1;
    num_blocks = (BLK_W+1)'(n);
    start = 1;
    @(negedge clk);
    start = 0;
    chk(rejected == 1 && busy == 0, {"R8 rejected pulse ", tag}, {rejected, busy}, 2);
    @(negedge clk);
    chk(rejected == 0 && rd_req == 0, {"R8 no read ", tag}, {rejected, rd_req}, 0);
    repeat (4) @(negedge clk);
    chk(q.size() == 0 && rd_req == 0, {"R8 idle ", tag}, rd_req, 0);
    check_table(tag);
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      spr[i] = '1;
      exp_tbl[i] = 2'b00;
    end
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && rejected == 0, "R1 reset outputs", {busy, done, rejected}, 0);
    check_table("R1 reset table");
    rst_n = 1;

    // R4: small page, 8-bit bus; byte0/byte1 ignored
    spr[3][47:40] = 8'h00;
    spr[4][7:0] = 8'h00;
    spr[5][15:8] = 8'h00;
    run_scan(2, 5, 64, 32, 0, 0, 0, "R4 R6 R9 small page");

    // R5: large page, byte5 ignored
    spr[10][7:0] = 8'h7F;
    spr[11][47:40] = 8'h00;
    spr[13][15:8] = 8'h00;
    run_scan(10, 13, 64, 64, 0, 1, 0, "R5 R6 large page");

    // R3: 16-bit bus
    spr[20][7:0] = 8'hF0; spr[20][15:8] = 8'h0F;
    spr[21][15:8] = 8'hFE;
    run_scan(20, 22, 64, 32, 1, 0, 0, "R3 wide small page");
    spr[24][15:8] = 8'h7F;
    spr[25][47:40] = 8'h00;
    run_scan(24, 25, 64, 64, 1, 1, 0, "R3 wide large page");

    // R7: clamping of unspecified and oversized last index
    spr[18][47:40] = 8'h3C;
    run_scan(17, -1, 20, 16, 0, 0, 0, "R7 last all-ones");
    spr[15][7:0] = 8'h00;
    spr[16][47:40] = 8'hFE;
    run_scan(15, 50, 20, 16, 0, 0, 0, "R7 last beyond device");

    // R8: refused starts
    run_reject(-3, 64, "R8 negative first");
    run_reject(20, 20, "R8 first at count");

    // R9: inverted range
    run_scan(30, 25, 64, 32, 0, 0, 0, "R9 empty range");

    // R9: single block at the top of the table
    spr[63][47:40] = 8'h11;
    run_scan(63, 63, 64, 4, 0, 0, 0, "R9 single final block");

    // R10: start while busy is ignored
    spr[41][47:40] = 8'h00;
    spr[42][7:0] = 8'h00;
    run_scan(40, 43, 64, 8, 0, 0, 1, "R10 start while busy");

    finish_up();
  end
endmodule